// File: doc/BRIEF.md
# Masked Priority Interrupt Concentrator

This block gathers sixteen level-sensitive interrupt lines from a local bus and folds them into one interrupt request towards the processor. On every clock each line's level is copied into its own bit of a pending-source register. A 16-bit enable mask, held in a small register window, selects which pending lines may raise the combined request.

Software uses two 16-bit locations. The mask location reads and writes the enable mask. The vector location does not return a bitmap. It returns a ready-to-use dispatch offset: the index of the lowest-numbered line that is both pending and enabled, plus one, shifted left by two bits. Zero means that nothing is pending. The lowest line index therefore has the highest priority. Reading has no side effect, so a handler may poll the vector as often as it likes.

Top module: `lbirq_concentrator`

## Requirements
- R1: After reset the enable mask is 0x0010, the source register is all zero, `irq_out` is 0 and `reg_rdata` is 0.
- R2: On every rising clock edge, bit i of the source register takes the level of `irq_lines[i]`: a high level sets it and a low level clears it.
- R3: `irq_out` is registered. After each rising edge it equals 1 exactly when (new source AND new mask) is nonzero, so it follows a line or mask change with one cycle of latency.
- R4: A read at byte offset 0x00 returns ((i+1) << 2), where i is the lowest set bit of (source AND mask). When that AND is zero, the read returns 0. Line 15 therefore reads 0x0040 and line 0 reads 0x0004.
- R5: Byte offset 0x02 holds the enable mask. A write there stores `reg_wdata` from the next edge on, and a read there returns the stored mask.
- R6: A read at any offset other than 0x00 or 0x02 returns 0. A write to any other offset leaves the mask unchanged.
- R7: Reads do not change the source register. Back-to-back reads of offset 0x00 with steady inputs return the same value.
- R8: A pending line whose mask bit is 0 affects neither `irq_out` nor the vector read, even when its index is lower than that of an enabled pending line.
- R9: Read data appears on `reg_rdata` on the edge that samples `reg_rd` high. It then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Level-sensitive interrupt lines |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rd | input | 1 | Read strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A corrupted source bit or mask bit shows at the ports within one cycle. `irq_out` misses the change one edge after a line moves, and the next vector read names the wrong line or returns zero. A broken priority chain shows only when two or more enabled lines are pending at once, so the stimulus sets many lines together, including masked low-index lines below enabled ones. A mask write landing at a wrong offset shows when the mask is read back, and as changed interrupt behaviour.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_VEC  = 2'd1,
        SEL_MASK = 2'd2
    } lbirq_sel_e;
endpackage

// File: rtl/lbirq_addr_dec.sv
module lbirq_addr_dec
    import lbirq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] VEC_OFS  = '0,
    parameter logic [ADDR_W-1:0] MASK_OFS = ADDR_W'(2)
) (
    input  logic [ADDR_W-1:0] addr,
    output lbirq_sel_e        sel
);
    always_comb begin
        if (addr == VEC_OFS)       sel = SEL_VEC;
        else if (addr == MASK_OFS) sel = SEL_MASK;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/lbirq_prio_enc.sv
module lbirq_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N:0]   below;
    logic [N-1:0] first;

    assign below[0] = 1'b0;

    // prefix-OR chain: a bit wins only when nothing below it is set
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign first[g]   = req[g] & ~below[g];
        assign below[g+1] = below[g] | req[g];
    end

    assign any = below[N];

    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (first[k]) idx = idx | IDX_W'(k);
        end
    end
endmodule

// File: rtl/lbirq_concentrator.sv
module lbirq_concentrator
    import lbirq_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int REG_W   = 16,
    parameter int ADDR_W  = 12,
    parameter logic [N_LINES-1:0] MASK_RST = N_LINES'(16'h0010),
    parameter logic [ADDR_W-1:0]  VEC_OFS  = '0,
    parameter logic [ADDR_W-1:0]  MASK_OFS = ADDR_W'(2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq_out
);
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    typedef struct packed {
        logic [N_LINES-1:0] src;
        logic [N_LINES-1:0] mask;
        logic               irq;
        logic [REG_W-1:0]   rdata;
    } state_t;

    localparam state_t RST_STATE = '{src: '0, mask: MASK_RST, irq: 1'b0, rdata: '0};

    state_t             st_d, st_q;
    lbirq_sel_e         sel;
    logic [N_LINES-1:0] pend_q;
    logic               pend_any;
    logic [IDX_W-1:0]   pend_idx;
    logic [REG_W-1:0]   vec_word;

    lbirq_addr_dec #(
        .ADDR_W   (ADDR_W),
        .VEC_OFS  (VEC_OFS),
        .MASK_OFS (MASK_OFS)
    ) dec_i (
        .addr (reg_addr),
        .sel  (sel)
    );

    assign pend_q = st_q.src & st_q.mask;

    lbirq_prio_enc #(
        .N     (N_LINES),
        .IDX_W (IDX_W)
    ) enc_i (
        .req (pend_q),
        .any (pend_any),
        .idx (pend_idx)
    );

    assign vec_word = pend_any ? ((REG_W'(pend_idx) + REG_W'(1)) << 2) : '0;

    always_comb begin
        st_d     = st_q;
        st_d.src = irq_lines;
        if (reg_wr && sel == SEL_MASK) begin
            st_d.mask = reg_wdata[N_LINES-1:0];
        end
        st_d.irq = |(st_d.src & st_d.mask);
        if (reg_rd) begin
            unique case (sel)
                SEL_VEC:  st_d.rdata = vec_word;
                SEL_MASK: st_d.rdata = REG_W'(st_q.mask);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign irq_out   = st_q.irq;

    // R2: source follows the lines one edge later
    p_src_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.src == $past(irq_lines));

    // R3 / R8: request only when an enabled line is pending
    p_out_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (st_q.src & st_q.mask) != '0);

    // R5: mask write lands on the next edge
    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == MASK_OFS) |=> st_q.mask == $past(reg_wdata[N_LINES-1:0]));

    // R6: no other access changes the mask
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == MASK_OFS) |=> $stable(st_q.mask));

    // R6: unmapped reads return zero
    p_unmapped_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != VEC_OFS && reg_addr != MASK_OFS) |=> reg_rdata == '0);

    // R4: an empty vector read returns zero
    p_empty_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == VEC_OFS && (st_q.src & st_q.mask) == '0) |=> reg_rdata == '0);

    // R9: read data holds between reads
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/lbirq_concentrator_tb_top.sv
`timescale 1ns/1ps
module lbirq_concentrator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_src  = '0;
    logic [15:0] m_mask = 16'h0010;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    lbirq_concentrator dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(logic [15:0] s, logic [15:0] m);
        logic [15:0] p = s & m;
        for (int i = 0; i < 16; i++) begin
            if (p[i]) return 16'((i + 1) << 2);
        end
        return 16'h0000;
    endfunction

    // monitor: pops one expected read value after each sampled read
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen && rst_n) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected read", reg_rdata, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [11:0] a, logic [15:0] exp, string tag);
        reg_addr = a;
        reg_rd   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cyc();
        reg_rd = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        cyc();
        reg_wr = 1'b0;
        if (a == 12'h002) m_mask = d;
    endtask

    task automatic set_lines(logic [15:0] v);
        irq_lines = v;
        m_src     = v;
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 irq_out at reset", {15'd0, irq_out}, 16'h0000);
        check("R1 rdata at reset", reg_rdata, 16'h0000);
        rst_n = 1'b1;
        cyc();
        check("R1 irq_out after reset", {15'd0, irq_out}, 16'h0000);
        rd(12'h002, 16'h0010, "R1 mask reset value");
        rd(12'h000, 16'h0000, "R1 R4 empty vector");

        // R2 R3: enabled line 4 raises the request
        set_lines(16'h0010);
        check("R2 R3 irq_out line4", {15'd0, irq_out}, 16'h0001);
        rd(12'h000, 16'h0014, "R4 vector line4");

        // R8: masked line 0 below the enabled line 4
        set_lines(16'h0011);
        rd(12'h000, 16'h0014, "R8 masked low line ignored");
        set_lines(16'h0001);
        check("R8 masked line no irq", {15'd0, irq_out}, 16'h0000);

        // R5: open the mask fully
        wr(12'h002, 16'hFFFF);
        check("R5 R3 irq after mask write", {15'd0, irq_out}, 16'h0001);
        rd(12'h002, 16'hFFFF, "R5 mask readback");
        rd(12'h000, 16'h0004, "R4 vector line0");

        // R7: repeated reads, no side effect
        set_lines(16'h8400);
        rd(12'h000, 16'h002C, "R7 first read line10");
        rd(12'h000, 16'h002C, "R7 second read line10");

        // R4: top line
        wr(12'h002, 16'h8000);
        rd(12'h000, 16'h0040, "R4 vector line15");

        // R6: unmapped offsets
        wr(12'h004, 16'h0000);
        wr(12'h003, 16'h0000);
        rd(12'h002, 16'h8000, "R6 mask unchanged by stray write");
        check("R6 irq kept after stray write", {15'd0, irq_out}, 16'h0001);
        rd(12'h006, 16'h0000, "R6 unmapped read");
        rd(12'h001, 16'h0000, "R6 odd offset read");

        // R9: rdata holds with no read
        cyc();
        check("R9 rdata held", reg_rdata, 16'h0000);

        // R3: one-cycle latency on a falling line
        irq_lines = 16'h0000;
        m_src     = 16'h0000;
        #1;
        check("R3 irq before edge", {15'd0, irq_out}, 16'h0001);
        cyc();
        check("R3 irq after edge", {15'd0, irq_out}, 16'h0000);

        // R4: each line alone
        wr(12'h002, 16'hFFFF);
        for (int i = 0; i < 16; i++) begin
            set_lines(16'(1 << i));
            check("R2 R3 single line irq", {15'd0, irq_out}, 16'h0001);
            rd(12'h000, 16'((i + 1) << 2), "R4 single line vector");
        end

        // R3 R4 R8: mixed patterns
        lfsr = 16'hACE1;
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            irq_lines = lfsr;
            m_src     = lfsr;
            wr(12'h002, {lfsr[7:0], lfsr[15:8]} & 16'hF3CF);
            check("R3 pattern irq", {15'd0, irq_out}, {15'd0, |(m_src & m_mask)});
            rd(12'h000, exp_vec(m_src, m_mask), "R4 R8 pattern vector");
        end

        // R5: mask cleared drops the request
        wr(12'h002, 16'h0000);
        check("R5 R3 mask zero irq", {15'd0, irq_out}, 16'h0000);
        rd(12'h000, 16'h0000, "R4 vector with zero mask");

        cyc();
        check("R9 queue drained", 16'(exp_q.size()), 16'h0000);
        finish_run();
    end
endmodule